// File: doc/BRIEF.md
# Hybrid Hash and Overflow-CAM Signature Matcher

This block decides whether a fixed-width key equals one of a stored set of signatures and, if it does, returns that signature's identifier. The main path reduces the key to a CRC-16 value. The low bits of that value select one word of a table, and each word holds one signature, its identifier and a valid flag. The word is read out and compared with the key in full. Signatures that could not get their own table word, because another signature already owns that slot, are held in a small fully associative CAM. The CAM is searched with the same key in the same cycle, so a collision never costs extra lookups or variable latency.

Keys arrive on a valid/ready input, and the block takes one per clock. The result comes out one cycle later and carries a match flag, the identifier and a flag that says which path found it. A separate write port installs, replaces or retires entries in either store while the block runs. The placement of each signature in table or CAM is decided outside the block.

Top module: `hcam_matcher`

## Requirements
- R1: The table index is the low IDX_W bits of a CRC-16 over the key. The CRC starts from 0x0000, takes key bit 0 first, and uses the reflected polynomial 0xA001: for each bit, feedback = crc[0] xor key bit, crc shifts right by one, and if the feedback is 1 the value is xored with 0xA001.
- R2: `in_ready` is high on every cycle after reset is released, so one key is accepted per cycle. `res_valid` is high in the cycle after each accepted key, and `res_*` describe that key.
- R3: A table word that is valid and whose signature equals the key gives `res_match`=1, its identifier, and `res_src`=0 (hash path).
- R4: A table word whose valid flag is 0 never matches, whatever signature it holds.
- R5: A valid CAM entry whose signature equals the key gives `res_match`=1, its identifier, and `res_src`=1 (CAM path).
- R6: If several valid CAM entries match, the one with the lowest index supplies the identifier.
- R7: If the table and the CAM both match, the table result is reported with `res_src`=0.
- R8: A key that matches nowhere gives `res_match`=0, `res_id`=0 and `res_src`=0.
- R9: A pulse on `wr_en` writes signature, identifier and valid flag to the table word `wr_addr[IDX_W-1:0]` when `wr_sel`=0, or to the CAM entry `wr_addr[CAM_AW-1:0]` when `wr_sel`=1. A key accepted in the next cycle sees the new contents. Writing valid=0 retires the entry.
- R10: Synchronous active-low reset clears every table and CAM valid flag and drives `res_valid` and `in_ready` low.
- R11: In a cycle with no accepted key, `res_valid` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Key is presented |
| in_ready | output | 1 | Block accepts a key this cycle |
| in_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result of the key accepted last cycle |
| res_match | output | 1 | Key matched a stored signature |
| res_id | output | ID_W | Identifier of the matched signature, 0 on a miss |
| res_src | output | 1 | 0: table path, 1: CAM path |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0: table word, 1: CAM entry |
| wr_addr | input | WA_W | Table index or CAM slot |
| wr_valid | input | 1 | Valid flag written with the entry |
| wr_sig | input | KEY_W | Signature written |
| wr_id | input | ID_W | Identifier written |

## Verification
The hardest situation to reach from the ports is a real hash collision: two different keys whose CRC values agree in the low IDX_W bits. Only then does the CAM legitimately back up the table. Because the CRC is linear over XOR, the bench searches for a nonzero difference word whose CRC has all-zero index bits. XORing that word onto an installed key gives a second key that lands in the same table slot. That second key is then placed in the CAM, overlapped with CAM duplicates and table duplicates, and has its table word retired, so the priority rules are exercised under an actual collision.

// File: rtl/hcam_pkg.sv
// Package: shared constants and types for the hybrid hash/CAM matcher.
// Assumes: nothing beyond IEEE 1800-2017.
package hcam_pkg;
    // Reflected form of the CRC-16 generator used for the hash key.
    localparam logic [15:0] CRC_POLY = 16'hA001;

    // Which lookup path produced a hit.
    typedef enum logic {
        SRC_HASH = 1'b0,
        SRC_CAM  = 1'b1
    } hit_src_e;
endpackage

// File: rtl/hcam_crc_index.sv
// Module: reduces a key to a table index with a bit-serial CRC-16
// unrolled into combinational logic (key bit 0 first, seed 0x0000).
// Assumes: IDX_W <= 16.
module hcam_crc_index #(
    parameter int KEY_W = 32,
    parameter int IDX_W = 10
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    import hcam_pkg::*;

    logic [15:0] crc;

    // Purpose: unrolled LSB-first CRC over every key bit.
    always_comb begin
        crc = 16'h0000;
        for (int b = 0; b < KEY_W; b++) begin
            if (crc[0] ^ key[b]) crc = (crc >> 1) ^ CRC_POLY;
            else                 crc = crc >> 1;
        end
        idx = crc[IDX_W-1:0];
    end
endmodule

// File: rtl/hcam_hash_table.sv
// Module: direct-mapped signature table, one write port and one
// combinational read port, with a per-word valid flag.
// Assumes: reads are asynchronous, so a write lands before the next read.
module hcam_hash_table #(
    parameter int KEY_W = 32,
    parameter int ID_W  = 8,
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_valid,
    input  logic [KEY_W-1:0] w_sig,
    input  logic [ID_W-1:0]  w_id,
    input  logic [IDX_W-1:0] r_idx,
    input  logic [KEY_W-1:0] r_key,
    output logic             r_hit,
    output logic [ID_W-1:0]  r_id
);
    logic [KEY_W-1:0] sig_mem [DEPTH];
    logic [ID_W-1:0]  id_mem  [DEPTH];
    logic [DEPTH-1:0] vld;

    // Purpose: store signature and identifier (no reset on data).
    always_ff @(posedge clk) begin
        if (we) begin
            sig_mem[w_idx] <= w_sig;
            id_mem[w_idx]  <= w_id;
        end
    end

    // Purpose: keep valid flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  vld        <= '0;
        else if (we) vld[w_idx] <= w_valid;
    end

    // Purpose: read the addressed word and compare it with the key.
    always_comb begin
        r_hit = vld[r_idx] && (sig_mem[r_idx] == r_key);
        r_id  = id_mem[r_idx];
    end

    // R9: a table write sets the word's flag as requested by the next cycle.
    a_r9_table_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we) |=> (vld[$past(w_idx)] == $past(w_valid)));
endmodule

// File: rtl/hcam_overflow_cam.sv
// Module: fully associative store for colliding signatures; all entries
// compare in parallel and the lowest matching index wins.
// Assumes: CAM_N is a power of two.
module hcam_overflow_cam #(
    parameter int KEY_W = 32,
    parameter int ID_W  = 8,
    parameter int CAM_N = 64,
    localparam int CAM_AW = $clog2(CAM_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CAM_AW-1:0] w_slot,
    input  logic              w_valid,
    input  logic [KEY_W-1:0]  w_sig,
    input  logic [ID_W-1:0]   w_id,
    input  logic [KEY_W-1:0]  s_key,
    output logic              s_hit,
    output logic [ID_W-1:0]   s_id
);
    logic [KEY_W-1:0]  sig_q [CAM_N];
    logic [ID_W-1:0]   id_q  [CAM_N];
    logic [CAM_N-1:0]  vld;
    logic [CAM_N-1:0]  eq;
    logic [CAM_AW-1:0] win;

    // Purpose: store signature and identifier for the addressed slot.
    always_ff @(posedge clk) begin
        if (we) begin
            sig_q[w_slot] <= w_sig;
            id_q[w_slot]  <= w_id;
        end
    end

    // Purpose: keep per-slot valid flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  vld         <= '0;
        else if (we) vld[w_slot] <= w_valid;
    end

    // One comparator per slot.
    for (genvar s = 0; s < CAM_N; s++) begin : g_cmp
        assign eq[s] = vld[s] && (sig_q[s] == s_key);
    end

    // Purpose: priority-encode the match vector toward the lowest slot.
    always_comb begin
        s_hit = 1'b0;
        win   = '0;
        for (int s = CAM_N - 1; s >= 0; s--) begin
            if (eq[s]) begin
                s_hit = 1'b1;
                win   = CAM_AW'(s);
            end
        end
        s_id = id_q[win];
    end

    // R9: a CAM write sets the slot's flag as requested by the next cycle.
    a_r9_cam_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we) |=> (vld[$past(w_slot)] == $past(w_valid)));
endmodule

// File: rtl/hcam_matcher.sv
// Module: top of the hybrid matcher. Hashes the key, reads the table and
// searches the CAM in the same cycle, merges with table priority and
// registers the result.
// Assumes: entry placement (table slot or CAM slot) is chosen by the writer.
module hcam_matcher #(
    parameter int KEY_W = 32,
    parameter int ID_W  = 8,
    parameter int IDX_W = 10,
    parameter int CAM_N = 64,
    localparam int CAM_AW = $clog2(CAM_N),
    localparam int WA_W   = (IDX_W > CAM_AW) ? IDX_W : CAM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic             res_valid,
    output logic             res_match,
    output logic [ID_W-1:0]  res_id,
    output logic             res_src,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WA_W-1:0]  wr_addr,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_sig,
    input  logic [ID_W-1:0]  wr_id
);
    import hcam_pkg::*;

    logic [IDX_W-1:0] h_idx;
    logic             t_hit, c_hit;
    logic [ID_W-1:0]  t_id, c_id;
    logic             accept;
    logic             nx_match;
    logic [ID_W-1:0]  nx_id;
    hit_src_e         nx_src;

    assign accept = in_valid && in_ready;

    hcam_crc_index #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_crc (
        .key (in_key),
        .idx (h_idx)
    );

    hcam_hash_table #(.KEY_W(KEY_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && !wr_sel),
        .w_idx   (wr_addr[IDX_W-1:0]),
        .w_valid (wr_valid),
        .w_sig   (wr_sig),
        .w_id    (wr_id),
        .r_idx   (h_idx),
        .r_key   (in_key),
        .r_hit   (t_hit),
        .r_id    (t_id)
    );

    hcam_overflow_cam #(.KEY_W(KEY_W), .ID_W(ID_W), .CAM_N(CAM_N)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && wr_sel),
        .w_slot  (wr_addr[CAM_AW-1:0]),
        .w_valid (wr_valid),
        .w_sig   (wr_sig),
        .w_id    (wr_id),
        .s_key   (in_key),
        .s_hit   (c_hit),
        .s_id    (c_id)
    );

    // Purpose: merge both paths, the table taking priority.
    always_comb begin
        nx_match = 1'b0;
        nx_id    = '0;
        nx_src   = SRC_HASH;
        if (t_hit) begin
            nx_match = 1'b1;
            nx_id    = t_id;
        end else if (c_hit) begin
            nx_match = 1'b1;
            nx_id    = c_id;
            nx_src   = SRC_CAM;
        end
    end

    // Purpose: hold ready low in reset and high afterwards.
    always_ff @(posedge clk) begin
        in_ready <= rst_n;
    end

    // Purpose: register the merged result of each accepted key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_id    <= '0;
            res_src   <= 1'b0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_match <= nx_match;
                res_id    <= nx_id;
                res_src   <= nx_src;
            end
        end
    end

    // R2: every accepted key yields a result in the next cycle.
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid);

    // R11: no accepted key, no result next cycle.
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !res_valid);

    // R8: a miss carries a zero identifier and the hash source code.
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_id == '0 && res_src == 1'b0));

    // R5: a CAM-sourced result is always a match.
    a_r5_cam_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src) |-> res_match);

    // R10: ready is high in every cycle that follows a non-reset cycle.
    a_r10_ready_after_reset: assert property (@(posedge clk)
        rst_n |=> in_ready);
endmodule

// File: tb/tb_hcam_matcher.sv
`timescale 1ns/100ps
module tb_hcam_matcher;
    localparam int KEY_W  = 32;
    localparam int ID_W   = 8;
    localparam int IDX_W  = 10;
    localparam int CAM_N  = 64;
    localparam int CAM_AW = $clog2(CAM_N);
    localparam int WA_W   = (IDX_W > CAM_AW) ? IDX_W : CAM_AW;
    localparam int NV     = 8;

    // Stimulus vectors: key, identifier, and whether to install it in the table.
    localparam logic [KEY_W-1:0] V_KEY [NV] = '{32'h4745_5420, 32'h504F_5354, 32'h2F62_696E,
        32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0000, 32'hCAFE_F00D, 32'h1234_5678};
    localparam logic [ID_W-1:0]  V_ID  [NV] = '{8'h11, 8'h22, 8'h33, 8'h44,
        8'h55, 8'h66, 8'h77, 8'h88};
    localparam logic             V_INS [NV] = '{1'b1, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [KEY_W-1:0] in_key = '0;
    logic res_valid, res_match, res_src;
    logic [ID_W-1:0] res_id;
    logic wr_en = 1'b0, wr_sel = 1'b0, wr_valid = 1'b0;
    logic [WA_W-1:0] wr_addr = '0;
    logic [KEY_W-1:0] wr_sig = '0;
    logic [ID_W-1:0] wr_id = '0;

    int checks = 0;
    int errors = 0;

    // Bench-side model of both stores, built from the requirements.
    logic             m_tv [1 << IDX_W];
    logic [KEY_W-1:0] m_ts [1 << IDX_W];
    logic [ID_W-1:0]  m_ti [1 << IDX_W];
    logic             m_cv [CAM_N];
    logic [KEY_W-1:0] m_cs [CAM_N];
    logic [ID_W-1:0]  m_ci [CAM_N];

    always #2.5 clk = ~clk;

    hcam_matcher #(.KEY_W(KEY_W), .ID_W(ID_W), .IDX_W(IDX_W), .CAM_N(CAM_N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .res_valid(res_valid), .res_match(res_match),
        .res_id(res_id), .res_src(res_src), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_valid(wr_valid), .wr_sig(wr_sig), .wr_id(wr_id)
    );

    // R1: CRC-16, seed 0, bit 0 first, reflected polynomial 0xA001.
    function automatic logic [15:0] crc16(input logic [KEY_W-1:0] d);
        logic [15:0] c = 16'h0;
        for (int b = 0; b < KEY_W; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ 16'hA001;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [IDX_W-1:0] hidx(input logic [KEY_W-1:0] d);
        logic [15:0] c = crc16(d);
        return c[IDX_W-1:0];
    endfunction

    // Expected {match, src, id} for a key under R3..R8.
    function automatic logic [ID_W+1:0] model(input logic [KEY_W-1:0] k);
        logic [IDX_W-1:0] i = hidx(k);
        if (m_tv[i] && m_ts[i] == k) return {1'b1, 1'b0, m_ti[i]};
        for (int s = 0; s < CAM_N; s++)
            if (m_cv[s] && m_cs[s] == k) return {1'b1, 1'b1, m_ci[s]};
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write pulse; returns at the negedge just after the write edge.
    task automatic wr(input logic sel, input int addr, input logic v,
                      input logic [KEY_W-1:0] sig, input logic [ID_W-1:0] id);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = WA_W'(addr);
        wr_valid = v; wr_sig = sig; wr_id = id;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) begin m_cv[addr] = v; m_cs[addr] = sig; m_ci[addr] = id; end
        else     begin m_tv[addr] = v; m_ts[addr] = sig; m_ti[addr] = id; end
    endtask

    // One lookup; samples the registered result at the following negedge.
    task automatic look(input logic [KEY_W-1:0] k);
        @(negedge clk);
        in_valid = 1'b1; in_key = k;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic m, input logic s,
                              input logic [ID_W-1:0] id);
        chk({req, " valid"}, 32'(res_valid), 32'd1);
        chk({req, " match"}, 32'(res_match), 32'(m));
        chk({req, " src"},   32'(res_src),   32'(s));
        chk({req, " id"},    32'(res_id),    32'(id));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [KEY_W-1:0] dnull, ka, kb, kc;
        logic [ID_W+1:0] e;
        for (int i = 0; i < (1 << IDX_W); i++) m_tv[i] = 1'b0;
        for (int i = 0; i < CAM_N; i++) m_cv[i] = 1'b0;

        // Find a difference word whose CRC index bits are zero (collision maker).
        dnull = '0;
        for (int d = 1; d < (1 << 22); d++) begin
            if (hidx(KEY_W'(d)) == '0) begin dnull = KEY_W'(d); break; end
        end

        // R10: reset state.
        repeat (3) @(negedge clk);
        chk("R10 res_valid in reset", 32'(res_valid), 32'd0);
        chk("R10 in_ready in reset", 32'(in_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 in_ready after reset", 32'(in_ready), 32'd1);
        look(32'h0000_0000);
        expect_res("R10 cleared table miss", 1'b0, 1'b0, '0);

        // Vector walk: install flagged vectors at their CRC index (R1, R3).
        for (int v = 0; v < NV; v++)
            if (V_INS[v]) wr(1'b0, int'(hidx(V_KEY[v])), 1'b1, V_KEY[v], V_ID[v]);
        for (int v = 0; v < NV; v++) begin
            look(V_KEY[v]);
            e = model(V_KEY[v]);
            expect_res(V_INS[v] ? "R3 vector hit" : "R8 vector miss", e[ID_W+1], e[ID_W], e[ID_W-1:0]);
            look(V_KEY[v] ^ 32'h0100_0000);
            e = model(V_KEY[v] ^ 32'h0100_0000);
            expect_res("R8 perturbed key", e[ID_W+1], e[ID_W], e[ID_W-1:0]);
        end

        // R1: an entry placed at the wrong index is not found.
        kc = 32'hCAFE_F00D;
        wr(1'b0, int'(hidx(kc) ^ 10'h001), 1'b1, kc, 8'h9C);
        look(kc);
        expect_res("R1 wrong index misses", 1'b0, 1'b0, '0);

        // R5: colliding key in the CAM resolves under a real collision.
        ka = V_KEY[0];
        kb = ka ^ dnull;
        chk("R1 collision pair same index", 32'(hidx(kb)), 32'(hidx(ka)));
        wr(1'b1, 5, 1'b1, kb, 8'hB5);
        look(kb);
        expect_res("R5 collision via CAM", 1'b1, 1'b1, 8'hB5);
        look(ka);
        expect_res("R3 slot owner still hits", 1'b1, 1'b0, V_ID[0]);

        // R6: two CAM entries match; lowest slot wins.
        wr(1'b1, 9, 1'b1, kb, 8'hC9);
        wr(1'b1, 3, 1'b1, kb, 8'hC3);
        look(kb);
        expect_res("R6 lowest slot wins", 1'b1, 1'b1, 8'hC3);

        // R9: retire slot 3 and look up in the very next cycle.
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_addr = WA_W'(3); wr_valid = 1'b0;
        wr_sig = kb; wr_id = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0; m_cv[3] = 1'b0;
        in_valid = 1'b1; in_key = kb;
        @(negedge clk);
        in_valid = 1'b0;
        expect_res("R9 next-cycle sees retire", 1'b1, 1'b1, 8'hB5);

        // R7: same key in table and CAM; table wins.
        wr(1'b1, 0, 1'b1, ka, 8'hEE);
        look(ka);
        expect_res("R7 table priority", 1'b1, 1'b0, V_ID[0]);

        // R4: invalid table word with the matching signature falls to the CAM.
        wr(1'b0, int'(hidx(ka)), 1'b0, ka, V_ID[0]);
        look(ka);
        expect_res("R4 invalid word ignored", 1'b1, 1'b1, 8'hEE);
        wr(1'b0, int'(hidx(V_KEY[1])), 1'b0, V_KEY[1], V_ID[1]);
        look(V_KEY[1]);
        expect_res("R4 invalid word no CAM", 1'b0, 1'b0, '0);

        // R2: back-to-back keys, one per cycle.
        @(negedge clk);
        in_valid = 1'b1; in_key = V_KEY[2];
        @(negedge clk);
        in_key = kb;
        expect_res("R2 burst 0", 1'b1, 1'b0, V_ID[2]);
        @(negedge clk);
        in_key = 32'h7777_7777;
        expect_res("R2 burst 1", 1'b1, 1'b1, 8'hB5);
        @(negedge clk);
        in_valid = 1'b0;
        e = model(32'h7777_7777);
        expect_res("R2 burst 2", e[ID_W+1], e[ID_W], e[ID_W-1:0]);

        // R11: idle cycle yields no result.
        @(negedge clk);
        chk("R11 idle no result", 32'(res_valid), 32'd0);

        // R10: reset clears installed entries.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look(V_KEY[2]);
        expect_res("R10 reset clears table", 1'b0, 1'b0, '0);
        look(kb);
        expect_res("R10 reset clears CAM", 1'b0, 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule